// File: doc/BRIEF.md
# Parallel Ten-Word Log-Domain Classifier

This block scores one utterance against ten stored word models at the same time and names the model that fits best. Each model is a small hidden Markov model kept entirely in on-chip tables: a start cost per state, a state-to-state move cost, and an emission cost per state and codebook symbol. All costs are non-negative fixed-point negative-log values, so a product of probabilities becomes a sum of costs and the most probable model is the one with the lowest accumulated cost.

A processor drives the block through a custom-instruction style port. One command opcode writes table entries. Another pushes a 32-bit word that carries up to four 7-bit codebook symbols; the block hands them out one at a time to all ten scorers, and it only moves to the next symbol once every scorer has finished the current time step. A finish command makes every scorer reduce its path costs to one final cost, and a compare stage then returns the winning digit and its cost. A clear command starts a fresh utterance without touching the tables.

Top module: `wc_digit_classifier`

## Requirements
- R1: A pushed word holds symbols in bits [6:0], [14:8], [22:16] and [30:24], applied in that order (lowest bits first); bits 7, 15, 23 and 31 are ignored.
- R2: The 3-bit count of a push (ci_cnt) picks how many symbols of the word are applied: 1 to 4 apply that many from the low end, 0 applies none, 5 to 7 apply all four.
- R3: For each model and state j, the first symbol o after a clear gives cost start[j] + emit[j][o]; each later symbol gives min over i of (cost[i] + move[i][j]) + emit[j][o]. Every sum saturates at 65535.
- R4: On a finish command (ci_op = 2) each model's final cost is the minimum of its state costs; the result carries the model index with the lowest final cost in bits [3:0], that cost in bits [31:16], and zero in bits [15:4].
- R5: When several models share the lowest final cost, the lowest model index wins.
- R6: A symbol is broadcast to all ten scorers together, and the next one is not issued until every scorer has completed the current step.
- R7: A clear command (ci_op = 3) returns every path cost to the empty state and keeps all tables; finishing an empty utterance returns digit 0 with cost 65535.
- R8: A table write (ci_op = 0) stores ci_datab[7:0] at the entry selected by ci_dataa: model [3:0], table [5:4] (0 start, 1 move, 2 emission), row state [9:6], column state [13:10] for moves, symbol [20:14] for emissions.
- R9: Each command accepted while idle gives exactly one one-cycle ci_done pulse; a ci_start raised while a command is in progress is ignored; the result is zero for every opcode other than finish (opcodes 4 to 7 do nothing).
- R10: After reset ci_done and ci_result are zero and all path costs are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ci_start | input | 1 | Command request, taken only when idle |
| ci_op | input | 3 | Opcode: 0 write, 1 push, 2 finish, 3 clear |
| ci_cnt | input | 3 | Number of symbols in a pushed word |
| ci_dataa | input | 32 | Pushed word, or table address for writes |
| ci_datab | input | 32 | Table value for writes (low 8 bits) |
| ci_done | output | 1 | One-cycle completion pulse |
| ci_result | output | 32 | Winner index and cost after finish, else zero |

## Verification
The bench goes after an exact cost tie between two models, where a compare using less-or-equal would report the higher index instead of digit 5, and a long run of expensive symbols, where a wrapping adder would leave small costs and hand the win to an arbitrary model instead of reporting 65535. It pushes words with the unused top bit of each byte set and with counts of 0, 2 and 6, which catch an unpacker that leaks bit 7 into a symbol, applies a zero-count word, or takes a count above four literally. A clear raised while a push is still running must neither produce a second done pulse nor wipe the costs, and a clear followed by a new utterance must reproduce earlier winners, showing that the tables survived.

// File: rtl/wc_pkg.sv
package wc_pkg;
    localparam int WORD_W  = 32;
    localparam int OBS_W   = 7;
    localparam int LANE_W  = 8;
    localparam int LANES   = WORD_W / LANE_W;
    localparam int CNT_W   = 3;
    localparam int OP_W    = 3;
    localparam int COST_W  = 8;
    localparam int SCORE_W = 16;
    localparam int FLD_W   = 4;

    // field positions inside the write address operand
    localparam int A_MODEL_LSB = 0;
    localparam int A_TBL_LSB   = 4;
    localparam int A_ROW_LSB   = 6;
    localparam int A_COL_LSB   = 10;
    localparam int A_CODE_LSB  = 14;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD   = 3'd0,
        OP_PUSH   = 3'd1,
        OP_FINISH = 3'd2,
        OP_CLEAR  = 3'd3
    } op_e;

    typedef enum logic [1:0] {
        TBL_START = 2'd0,
        TBL_MOVE  = 2'd1,
        TBL_EMIT  = 2'd2,
        TBL_NONE  = 2'd3
    } tbl_e;
endpackage

// File: rtl/wc_model_scorer.sv
module wc_model_scorer
    import wc_pkg::*;
#(
    parameter int N_STATES = 3,
    parameter int CODE_W   = OBS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_tbl_i,
    input  logic [FLD_W-1:0]   wr_row_i,
    input  logic [FLD_W-1:0]   wr_col_i,
    input  logic [CODE_W-1:0]  wr_code_i,
    input  logic [COST_W-1:0]  wr_val_i,
    input  logic               step_i,
    input  logic [CODE_W-1:0]  code_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [SCORE_W-1:0] final_o
);
    localparam int CODES = 1 << CODE_W;
    localparam int ST_W  = (N_STATES > 1) ? $clog2(N_STATES) : 1;
    localparam logic [SCORE_W-1:0] SAT     = '1;
    localparam logic [ST_W-1:0]    LAST_ST = ST_W'(N_STATES - 1);

    logic [COST_W-1:0] start_mem [N_STATES];
    logic [COST_W-1:0] move_mem  [N_STATES][N_STATES];
    logic [COST_W-1:0] emit_mem  [N_STATES][CODES];

    typedef struct packed {
        logic [N_STATES-1:0][SCORE_W-1:0] path;
        logic [N_STATES-1:0][SCORE_W-1:0] fresh;
        logic [ST_W-1:0]                  st;
        logic [CODE_W-1:0]                code;
        logic                             first;
        logic                             busy;
        logic                             done;
    } sc_t;

    sc_t sc_d, sc_q;
    logic [SCORE_W-1:0] best_in, entry, cand, via, low;

    function automatic logic [SCORE_W-1:0] sat_add(input logic [SCORE_W-1:0] a,
                                                   input logic [SCORE_W-1:0] b);
        logic [SCORE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[SCORE_W] ? SAT : s[SCORE_W-1:0];
    endfunction

    // table storage: written only by the load port, never reset
    always_ff @(posedge clk) begin
        if (wr_en_i && (int'(wr_row_i) < N_STATES)) begin
            case (wr_tbl_i)
                TBL_START: start_mem[wr_row_i[ST_W-1:0]] <= wr_val_i;
                TBL_MOVE:  if (int'(wr_col_i) < N_STATES)
                               move_mem[wr_row_i[ST_W-1:0]][wr_col_i[ST_W-1:0]] <= wr_val_i;
                TBL_EMIT:  emit_mem[wr_row_i[ST_W-1:0]][wr_code_i] <= wr_val_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        sc_d      = sc_q;
        sc_d.done = 1'b0;
        best_in   = SAT;
        for (int i = 0; i < N_STATES; i++) begin
            via = sat_add(sc_q.path[i], SCORE_W'(move_mem[i][sc_q.st]));
            if (via < best_in) best_in = via;
        end
        entry = sc_q.first ? SCORE_W'(start_mem[sc_q.st]) : best_in;
        cand  = sat_add(entry, SCORE_W'(emit_mem[sc_q.st][sc_q.code]));

        if (clr_i) begin
            sc_d.path  = '1;
            sc_d.fresh = '1;
            sc_d.first = 1'b1;
            sc_d.busy  = 1'b0;
            sc_d.st    = '0;
        end else if (sc_q.busy) begin
            sc_d.fresh[sc_q.st] = cand;
            if (sc_q.st == LAST_ST) begin
                sc_d.path  = sc_d.fresh;
                sc_d.first = 1'b0;
                sc_d.busy  = 1'b0;
                sc_d.done  = 1'b1;
            end else begin
                sc_d.st = sc_q.st + 1'b1;
            end
        end else if (step_i) begin
            sc_d.busy = 1'b1;
            sc_d.st   = '0;
            sc_d.code = code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q       <= '0;
            sc_q.path  <= '1;
            sc_q.fresh <= '1;
            sc_q.first <= 1'b1;
        end else begin
            sc_q <= sc_d;
        end
    end

    always_comb begin
        low = SAT;
        for (int i = 0; i < N_STATES; i++)
            if (sc_q.path[i] < low) low = sc_q.path[i];
    end

    assign final_o = low;
    assign busy_o  = sc_q.busy;
    assign done_o  = sc_q.done;

    // R3: a completed step is always preceded by a busy cycle
    p_step_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(sc_q.busy));
    // R7: a clear leaves the scorer idle with empty costs
    p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!busy_o && final_o == SAT));
endmodule

// File: rtl/wc_obs_feeder.sv
module wc_obs_feeder
    import wc_pkg::*;
#(
    parameter int N_MODELS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [WORD_W-1:0]   word_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [N_MODELS-1:0] done_vec_i,
    output logic                step_o,
    output logic [OBS_W-1:0]    code_o,
    output logic                fin_o
);
    typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_WAIT} ph_e;

    typedef struct packed {
        ph_e                 ph;
        logic [WORD_W-1:0]   word;
        logic [CNT_W-1:0]    left;
        logic [N_MODELS-1:0] seen;
        logic                fin;
    } fd_t;

    fd_t fd_d, fd_q;
    logic [CNT_W-1:0] take;

    assign take = (cnt_i > CNT_W'(LANES)) ? CNT_W'(LANES) : cnt_i;

    always_comb begin
        fd_d     = fd_q;
        fd_d.fin = 1'b0;
        case (fd_q.ph)
            F_IDLE: begin
                if (load_i) begin
                    if (take == '0) begin
                        fd_d.fin = 1'b1;
                    end else begin
                        fd_d.ph   = F_ISSUE;
                        fd_d.word = word_i;
                        fd_d.left = take;
                    end
                end
            end
            F_ISSUE: begin
                fd_d.ph   = F_WAIT;
                fd_d.seen = '0;
            end
            F_WAIT: begin
                fd_d.seen = fd_q.seen | done_vec_i;
                if (&fd_d.seen) begin
                    fd_d.word = fd_q.word >> LANE_W;
                    if (fd_q.left == CNT_W'(1)) begin
                        fd_d.ph  = F_IDLE;
                        fd_d.fin = 1'b1;
                    end else begin
                        fd_d.left = fd_q.left - 1'b1;
                        fd_d.ph   = F_ISSUE;
                    end
                end
            end
            default: fd_d.ph = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fd_q <= '0;
        else        fd_q <= fd_d;
    end

    assign step_o = (fd_q.ph == F_ISSUE);
    assign code_o = fd_q.word[OBS_W-1:0];
    assign fin_o  = fd_q.fin;

    // R2: one completion pulse per pushed word
    p_fin_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o);
    // R6: a step is issued only from a quiet feeder, never back to back
    p_step_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);
endmodule

// File: rtl/wc_best_select.sv
module wc_best_select #(
    parameter  int N_MODELS = 10,
    parameter  int SCORE_W  = 16,
    localparam int IDX_W    = $clog2(N_MODELS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [N_MODELS-1:0][SCORE_W-1:0]  cost_i,
    output logic                              fin_o,
    output logic [IDX_W-1:0]                  best_idx_o,
    output logic [SCORE_W-1:0]                best_cost_o
);
    localparam logic [IDX_W-1:0] LAST_M = IDX_W'(N_MODELS - 1);

    typedef struct packed {
        logic               busy;
        logic [IDX_W-1:0]   pos;
        logic [IDX_W-1:0]   best_idx;
        logic [SCORE_W-1:0] best_cost;
        logic               fin;
    } bs_t;

    bs_t bs_d, bs_q;

    always_comb begin
        bs_d     = bs_q;
        bs_d.fin = 1'b0;
        if (start_i) begin
            bs_d.busy      = 1'b1;
            bs_d.pos       = IDX_W'(1);
            bs_d.best_idx  = '0;
            bs_d.best_cost = cost_i[0];
        end else if (bs_q.busy) begin
            // strict compare keeps the earlier (lower) index on ties
            if (cost_i[bs_q.pos] < bs_q.best_cost) begin
                bs_d.best_cost = cost_i[bs_q.pos];
                bs_d.best_idx  = bs_q.pos;
            end
            if (bs_q.pos == LAST_M) begin
                bs_d.busy = 1'b0;
                bs_d.fin  = 1'b1;
            end else begin
                bs_d.pos = bs_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign fin_o       = bs_q.fin;
    assign best_idx_o  = bs_q.best_idx;
    assign best_cost_o = bs_q.best_cost;

    for (genvar m = 0; m < N_MODELS; m++) begin : g_chk
        // R4: the reported cost is no larger than any model's cost
        p_winner_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
            fin_o |-> (best_cost_o <= cost_i[m]));
        // R5: any model tied with the winner has an index no lower than it
        p_tie_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (fin_o && cost_i[m] == best_cost_o) |-> (IDX_W'(m) >= best_idx_o));
    end
endmodule

// File: rtl/wc_digit_classifier.sv
module wc_digit_classifier
    import wc_pkg::*;
#(
    parameter int N_MODELS = 10,
    parameter int N_STATES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ci_start,
    input  logic [OP_W-1:0]   ci_op,
    input  logic [CNT_W-1:0]  ci_cnt,
    input  logic [WORD_W-1:0] ci_dataa,
    input  logic [WORD_W-1:0] ci_datab,
    output logic              ci_done,
    output logic [WORD_W-1:0] ci_result
);
    localparam int IDX_W = $clog2(N_MODELS);

    typedef enum logic [1:0] {T_IDLE, T_FEED, T_PICK, T_DONE} top_e;

    typedef struct packed {
        top_e              st;
        logic [WORD_W-1:0] result;
    } tp_t;

    tp_t tp_d, tp_q;

    logic accept, is_load, is_push, is_finish, is_clear;
    logic feed_step, feed_fin, pick_fin;
    logic [OBS_W-1:0] feed_code;
    logic [N_MODELS-1:0] busy_vec, done_vec;
    logic [N_MODELS-1:0][SCORE_W-1:0] cost_vec;
    logic [IDX_W-1:0]   pick_idx;
    logic [SCORE_W-1:0] pick_cost;
    logic unused_bits;

    assign accept    = ci_start && (tp_q.st == T_IDLE);
    assign is_load   = accept && (ci_op == OP_LOAD);
    assign is_push   = accept && (ci_op == OP_PUSH);
    assign is_finish = accept && (ci_op == OP_FINISH);
    assign is_clear  = accept && (ci_op == OP_CLEAR);
    assign unused_bits = ^{ci_datab[WORD_W-1:COST_W], ci_dataa[WORD_W-1:A_CODE_LSB+OBS_W]};

    for (genvar m = 0; m < N_MODELS; m++) begin : g_model
        wc_model_scorer #(
            .N_STATES (N_STATES),
            .CODE_W   (OBS_W)
        ) u_scorer (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (is_clear),
            .wr_en_i   (is_load && (ci_dataa[A_MODEL_LSB +: FLD_W] == FLD_W'(m))),
            .wr_tbl_i  (ci_dataa[A_TBL_LSB +: 2]),
            .wr_row_i  (ci_dataa[A_ROW_LSB +: FLD_W]),
            .wr_col_i  (ci_dataa[A_COL_LSB +: FLD_W]),
            .wr_code_i (ci_dataa[A_CODE_LSB +: OBS_W]),
            .wr_val_i  (ci_datab[COST_W-1:0]),
            .step_i    (feed_step),
            .code_i    (feed_code),
            .busy_o    (busy_vec[m]),
            .done_o    (done_vec[m]),
            .final_o   (cost_vec[m])
        );
    end

    wc_obs_feeder #(.N_MODELS(N_MODELS)) u_feeder (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (is_push),
        .word_i     (ci_dataa),
        .cnt_i      (ci_cnt),
        .done_vec_i (done_vec),
        .step_o     (feed_step),
        .code_o     (feed_code),
        .fin_o      (feed_fin)
    );

    wc_best_select #(.N_MODELS(N_MODELS), .SCORE_W(SCORE_W)) u_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (is_finish),
        .cost_i      (cost_vec),
        .fin_o       (pick_fin),
        .best_idx_o  (pick_idx),
        .best_cost_o (pick_cost)
    );

    always_comb begin
        tp_d = tp_q;
        case (tp_q.st)
            T_IDLE: begin
                if (accept) begin
                    tp_d.result = '0;
                    if (is_push)        tp_d.st = T_FEED;
                    else if (is_finish) tp_d.st = T_PICK;
                    else                tp_d.st = T_DONE;
                end
            end
            T_FEED: if (feed_fin) tp_d.st = T_DONE;
            T_PICK: begin
                if (pick_fin) begin
                    tp_d.result = '0;
                    tp_d.result[WORD_W-1 -: SCORE_W] = pick_cost;
                    tp_d.result[IDX_W-1:0]           = pick_idx;
                    tp_d.st = T_DONE;
                end
            end
            default: tp_d.st = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign ci_done   = (tp_q.st == T_DONE);
    assign ci_result = tp_q.result;

    // R6: a symbol is broadcast only when no scorer is still working
    p_lockstep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        feed_step |-> (busy_vec == '0));
    // R6: all scorers finish a step in the same cycle
    p_done_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_vec) |-> (&done_vec));
    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ci_done |=> !ci_done);
    // R9: a start during a running command leaves the command running
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ci_start && tp_q.st == T_FEED && !feed_fin) |=> (tp_q.st == T_FEED));
endmodule

// File: tb/wc_digit_classifier_test.sv
module wc_digit_classifier_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ci_start = 1'b0;
    logic [2:0]  ci_op = '0;
    logic [2:0]  ci_cnt = '0;
    logic [31:0] ci_dataa = '0;
    logic [31:0] ci_datab = '0;
    logic        ci_done;
    logic [31:0] ci_result;

    int n_checks = 0;
    int n_fail = 0;

    int r_start [10][3];
    int r_move  [10][3][3];
    int r_emit  [10][3][128];
    int r_path  [10][3];
    bit r_first [10];

    // vector: {word0, cnt0, word1, cnt1}
    localparam logic [69:0] VEC [8] = '{
        {32'h03112205, 3'd4, 32'h40100802, 3'd4},
        {32'h7D6A5531, 3'd4, 32'h0000190C, 3'd2},
        {32'h8F90A1B2, 3'd4, 32'h13375B71, 3'd3},
        {32'h2A2A2A2A, 3'd4, 32'h2A2A2A2A, 3'd4},
        {32'h00010203, 3'd1, 32'h44332211, 3'd0},
        {32'h5C483420, 3'd4, 32'h604C3824, 3'd7},
        {32'h7C7C0000, 3'd4, 32'h1E3F5E6E, 3'd4},
        {32'h09182736, 3'd4, 32'h45546372, 3'd4}
    };

    wc_digit_classifier uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ci_start  (ci_start),
        .ci_op     (ci_op),
        .ci_cnt    (ci_cnt),
        .ci_dataa  (ci_dataa),
        .ci_datab  (ci_datab),
        .ci_done   (ci_done),
        .ci_result (ci_result)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > 65535) ? 65535 : v;
    endfunction

    function automatic int f_start(input int j);
        return (j == 0) ? 0 : 200;
    endfunction

    function automatic int f_move(input int i, input int j);
        if (j == i) return 2;
        if (j == i + 1) return 5;
        return 250;
    endfunction

    function automatic int f_emit(input int m, input int j, input int c);
        return ((c * (m + 3) + j * 29 + m * 7) % 61) + 5;
    endfunction

    task automatic ref_clear();
        for (int m = 0; m < 10; m++) begin
            r_first[m] = 1'b1;
            for (int j = 0; j < 3; j++) r_path[m][j] = 65535;
        end
    endtask

    task automatic ref_step(input int c);
        for (int m = 0; m < 10; m++) begin
            int nv [3];
            for (int j = 0; j < 3; j++) begin
                int b;
                if (r_first[m]) b = r_start[m][j];
                else begin
                    b = 65535;
                    for (int i = 0; i < 3; i++)
                        if (sat(r_path[m][i] + r_move[m][i][j]) < b)
                            b = sat(r_path[m][i] + r_move[m][i][j]);
                end
                nv[j] = sat(b + r_emit[m][j][c]);
            end
            for (int j = 0; j < 3; j++) r_path[m][j] = nv[j];
            r_first[m] = 1'b0;
        end
    endtask

    task automatic ref_push(input logic [31:0] w, input logic [2:0] cnt);
        int eff;
        eff = (cnt > 3'd4) ? 4 : int'(cnt);
        for (int k = 0; k < eff; k++) ref_step(int'((w >> (8 * k)) & 32'h7F));
    endtask

    function automatic logic [31:0] ref_result();
        int best_m, best_c;
        best_m = 0;
        best_c = 70000;
        for (int m = 0; m < 10; m++) begin
            int f;
            f = 65535;
            for (int j = 0; j < 3; j++) if (r_path[m][j] < f) f = r_path[m][j];
            if (f < best_c) begin
                best_c = f;
                best_m = m;
            end
        end
        return {best_c[15:0], 12'h000, best_m[3:0]};
    endfunction

    task automatic issue(input logic [2:0] op, input logic [2:0] cnt,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] res, output int cyc);
        @(negedge clk);
        ci_start = 1'b1;
        ci_op = op;
        ci_cnt = cnt;
        ci_dataa = a;
        ci_datab = b;
        @(negedge clk);
        ci_start = 1'b0;
        cyc = 1;
        while (!ci_done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        res = ci_result;
    endtask

    task automatic wr_param(input int m, input int tbl, input int row, input int col,
                            input int code, input int val);
        logic [31:0] a, res;
        int cyc;
        a = 32'(m) | (32'(tbl) << 4) | (32'(row) << 6) | (32'(col) << 10) | (32'(code) << 14);
        issue(3'd0, 3'd0, a, 32'(val), res, cyc);
        if (tbl == 0) r_start[m][row] = val;
        else if (tbl == 1) r_move[m][row][col] = val;
        else if (tbl == 2) r_emit[m][row][code] = val;
    endtask

    task automatic do_clear();
        logic [31:0] res;
        int cyc;
        issue(3'd3, 3'd0, 32'h0, 32'h0, res, cyc);
        ref_clear();
    endtask

    task automatic do_push(input logic [31:0] w, input logic [2:0] cnt, output int cyc);
        logic [31:0] res;
        issue(3'd1, cnt, w, 32'h0, res, cyc);
        ref_push(w, cnt);
    endtask

    task automatic do_finish(output logic [31:0] res);
        int cyc;
        issue(3'd2, 3'd0, 32'h0, 32'h0, res, cyc);
    endtask

    initial begin
        logic [31:0] res;
        int cyc;

        ref_clear();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 done low in reset", {31'b0, ci_done}, 32'h0);
        chk("R10 result zero in reset", ci_result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 done low after reset", {31'b0, ci_done}, 32'h0);

        // R7 R10: empty utterance after reset
        do_finish(res);
        chk("R7 empty utterance", res, 32'hFFFF0000);

        // R8: load every table entry through the write port
        for (int m = 0; m < 10; m++) begin
            for (int j = 0; j < 3; j++) wr_param(m, 0, j, 0, 0, f_start(j));
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++) wr_param(m, 1, i, j, 0, f_move(i, j));
            for (int j = 0; j < 3; j++)
                for (int c = 0; c < 128; c++) wr_param(m, 2, j, 0, c, f_emit(m, j, c));
        end

        // R9: non-finish opcodes return zero
        issue(3'd0, 3'd0, 32'h00000030, 32'h0, res, cyc);
        chk("R9 write result zero", res, 32'h0);
        issue(3'd7, 3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, res, cyc);
        chk("R9 unused opcode result zero", res, 32'h0);

        // R1 R2 R3 R4 R8: vector table
        for (int v = 0; v < 8; v++) begin
            logic [69:0] vec;
            vec = VEC[v];
            do_clear();
            do_push(vec[69:38], vec[37:35], cyc);
            do_push(vec[34:3], vec[2:0], cyc);
            do_finish(res);
            chk($sformatf("R4 R3 R1 vector %0d", v), res, ref_result());
        end

        // R6: four symbols each wait for every scorer
        do_clear();
        do_push(32'h11223344, 3'd4, cyc);
        chk("R6 push latency at least one step per symbol", 32'(cyc >= 12), 32'h1);
        do_finish(res);
        chk("R6 lock-step result", res, ref_result());

        // R2: zero count applies nothing
        do_clear();
        do_push(32'h11223344, 3'd0, cyc);
        do_finish(res);
        chk("R2 count zero leaves empty", res, 32'hFFFF0000);

        // R2: count six behaves as four
        do_clear();
        do_push(32'h05152535, 3'd6, cyc);
        do_finish(res);
        chk("R2 count six as four", res, ref_result());

        // R1: spare top bits of each byte are ignored
        do_clear();
        do_push(32'hC5D5E5F5, 3'd4, cyc);
        do_finish(res);
        begin
            logic [31:0] hi_res;
            hi_res = res;
            do_clear();
            do_push(32'h45556575, 3'd4, cyc);
            do_finish(res);
            chk("R1 high bits ignored", hi_res, res);
        end

        // R5 R8: exact tie between models 5 and 8 on symbol 127
        for (int m = 0; m < 10; m++)
            for (int j = 0; j < 3; j++)
                wr_param(m, 2, j, 0, 127, (m == 5 || m == 8) ? 0 : 200);
        do_clear();
        do_push(32'h7F7F7F7F, 3'd2, cyc);
        do_finish(res);
        chk("R5 tie picks lower index", res, {16'd2, 12'h000, 4'd5});
        chk("R5 tie matches reference", res, ref_result());

        // R3: costs saturate at 65535
        for (int m = 0; m < 10; m++)
            for (int j = 0; j < 3; j++) wr_param(m, 2, j, 0, 126, 255);
        do_clear();
        for (int k = 0; k < 64; k++) do_push(32'h7E7E7E7E, 3'd4, cyc);
        do_finish(res);
        chk("R3 saturation", res, 32'hFFFF0000);
        chk("R3 saturation reference", res, ref_result());

        // R9: start while a push runs is ignored
        do_clear();
        begin
            int dones;
            @(negedge clk);
            ci_start = 1'b1;
            ci_op = 3'd1;
            ci_cnt = 3'd4;
            ci_dataa = 32'h0A141E28;
            @(negedge clk);
            ci_op = 3'd3;
            @(negedge clk);
            ci_start = 1'b0;
            dones = 0;
            repeat (60) begin
                @(negedge clk);
                if (ci_done) dones++;
            end
            ref_push(32'h0A141E28, 3'd4);
            chk("R9 single done pulse", 32'(dones), 32'd1);
        end
        do_finish(res);
        chk("R9 ignored clear kept costs", res, ref_result());

        // R7: clear empties costs and keeps tables
        do_clear();
        do_finish(res);
        chk("R7 cleared empty", res, 32'hFFFF0000);
        do_push(VEC[0][69:38], VEC[0][37:35], cyc);
        do_push(VEC[0][34:3], VEC[0][2:0], cyc);
        do_finish(res);
        chk("R7 tables retained", res, ref_result());

        summary();
        $finish;
    end
endmodule